// File: doc/BRIEF.md
# Open-Drain Response Frame Transmitter

This block sends a fixed 16-bit response word onto a shared line that several stations can pull at once. A one bit turns the line driver on. A zero bit turns the driver off and leaves the line floating. The bus pin is modelled as an output-enable with a constant drive level, so the pad itself stays outside the block.

The word is assembled from a car number, a two-bit track-change code, the sender's own number and a device-type nibble. A framing bit equal to 1 is placed at each end of the word. Transmission starts on a one-cycle start request while the block is idle. The word then goes out least significant bit first, and each bit is held for a programmable number of clock-enable ticks. After the last bit the driver is released unconditionally. The busy flag stays high for one further quiet bit time, so another station sees a gap before the next frame.

Top module: `resp_frame_tx`

## Requirements
- R1: Out of reset, and whenever busy is low, busy and drive_en are 0, and drive_val is constantly 1.
- R2: A start seen at a clock edge while busy is low is accepted at that edge. The fields are sampled there, and from the next cycle busy is 1 and the frame's bit 0 is on the line.
- R3: The frame layout is fixed. Bit 0 carries framing. Bits 3:1 carry car_id. Bits 5:4 carry trk_status, where 0 means stayed on A, 1 means A to B, 2 means stayed on B and 3 means B to A. Bits 8:6 carry sender_id. Bits 12:9 carry dev_type. Bits 14:13 are reserved zeros. Bit 15 carries framing.
- R4: Frame bits 0 and 15 are always sent as 1, whatever the field inputs are.
- R5: Bits leave least significant first, in strictly ascending order with none skipped.
- R6: Each bit stays on the line for exactly BIT_TICKS cycles in which tick_en is high. Cycles with tick_en low do not advance the frame.
- R7: While a bit is on the line, drive_en equals that bit's value: 1 drives the line and 0 releases it.
- R8: Once bit 15 has had its full time, drive_en is 0 and stays 0 until the next frame is accepted.
- R9: busy falls exactly BIT_TICKS ticks after bit 15 ends, so a frame occupies 17 × BIT_TICKS ticks.
- R10: A start while busy is high is ignored. Field changes during a frame do not alter the bits being sent.
- R11: A start held high through the end of a frame is accepted at the first clock edge at which busy is low, and a new frame begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Bit-timing clock enable |
| start | input | 1 | Request to send one frame |
| car_id | input | 3 | Car number field |
| trk_status | input | 2 | Track-change code |
| sender_id | input | 3 | Own station number |
| dev_type | input | 4 | Device-type field |
| drive_en | output | 1 | Line driver enable (1 = pull line) |
| drive_val | output | 1 | Constant level driven when enabled (1) |
| busy | output | 1 | Frame or trailing gap in progress |

## Verification
The assertions check the following on every cycle:
- the line is never driven outside the data phase;
- an accepted start raises busy with the first framing bit on the line;
- the bit index only ever steps by one;
- the bit index is frozen on cycles without a tick;
- a start during a frame leaves the held word untouched;
- busy can only fall from the trailing gap.

Only the bench's scenarios can show that the value of each bit matches the packed fields and that the tick count of each bit and of the gap is exact. The bench's model counts ticks itself, which lets it cover this under random tick patterns, stalled ticks and start requests held back-to-back.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;

  localparam int FRAME_W  = 16;
  localparam int CAR_W    = 3;
  localparam int STAT_W   = 2;
  localparam int SID_W    = 3;
  localparam int DEV_W    = 4;
  localparam int CAR_LSB  = 1;
  localparam int STAT_LSB = CAR_LSB + CAR_W;
  localparam int SID_LSB  = STAT_LSB + STAT_W;
  localparam int DEV_LSB  = SID_LSB + SID_W;
  localparam int IDX_W    = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  typedef enum logic [STAT_W-1:0] {
    TRK_AA = 2'd0,
    TRK_AB = 2'd1,
    TRK_BB = 2'd2,
    TRK_BA = 2'd3
  } trk_code_t;

  // Places the fields; framing bits forced high, reserved bits left zero.
  function automatic frame_t pack_frame(
    input logic [CAR_W-1:0]  car,
    input logic [STAT_W-1:0] stat,
    input logic [SID_W-1:0]  sid,
    input logic [DEV_W-1:0]  dev
  );
    frame_t f;
    f = '0;
    f[CAR_LSB  +: CAR_W]  = car;
    f[STAT_LSB +: STAT_W] = stat;
    f[SID_LSB  +: SID_W]  = sid;
    f[DEV_LSB  +: DEV_W]  = dev;
    f[0]         = 1'b1;
    f[FRAME_W-1] = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/resp_bit_timer.sv
module resp_bit_timer #(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick_en,
  output logic bit_done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign bit_done = run && tick_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && tick_en)   cnt <= bit_done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/resp_seq_ctrl.sv
module resp_seq_ctrl
  import resp_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_done,
  output logic             load,
  output logic             busy,
  output logic             sending,
  output logic             in_tail,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  phase_t phase;

  assign load    = (phase == PH_IDLE) && start;
  assign busy    = (phase != PH_IDLE);
  assign sending = (phase == PH_SEND);
  assign in_tail = (phase == PH_TAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_SEND;
          bit_idx <= '0;
        end
        PH_SEND: if (bit_done) begin
          if (bit_idx == LAST_IDX) phase <= PH_TAIL;
          else                     bit_idx <= bit_idx + 1'b1;
        end
        PH_TAIL: if (bit_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resp_frame_pack.sv
module resp_frame_pack
  import resp_tx_pkg::*;
(
  input  logic [CAR_W-1:0]  car_id,
  input  logic [STAT_W-1:0] trk_status,
  input  logic [SID_W-1:0]  sender_id,
  input  logic [DEV_W-1:0]  dev_type,
  output frame_t            word
);
  assign word = pack_frame(car_id, trk_status, sender_id, dev_type);
endmodule

// File: rtl/resp_frame_tx.sv
module resp_frame_tx
  import resp_tx_pkg::*;
#(
  parameter int BIT_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start,
  input  logic [CAR_W-1:0]  car_id,
  input  logic [STAT_W-1:0] trk_status,
  input  logic [SID_W-1:0]  sender_id,
  input  logic [DEV_W-1:0]  dev_type,
  output logic              drive_en,
  output logic              drive_val,
  output logic              busy
);
  logic             load;
  logic             sending;
  logic             in_tail;
  logic             bit_done;
  logic [IDX_W-1:0] bit_idx;
  frame_t           packed_word;
  frame_t           frame_q;

  resp_frame_pack u_pack (
    .car_id     (car_id),
    .trk_status (trk_status),
    .sender_id  (sender_id),
    .dev_type   (dev_type),
    .word       (packed_word)
  );

  resp_bit_timer #(.TICKS(BIT_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .run      (busy),
    .tick_en  (tick_en),
    .bit_done (bit_done)
  );

  resp_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bit_done (bit_done),
    .load     (load),
    .busy     (busy),
    .sending  (sending),
    .in_tail  (in_tail),
    .bit_idx  (bit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    frame_q <= '0;
    else if (load) frame_q <= packed_word;
  end

  assign drive_en  = sending & frame_q[bit_idx];
  assign drive_val = 1'b1;
endmodule

// File: rtl/resp_frame_tx_chk.sv
module resp_frame_tx_chk
  import resp_tx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             tick_en,
  input logic             busy,
  input logic             drive_en,
  input logic             sending,
  input logic             in_tail,
  input logic [IDX_W-1:0] bit_idx,
  input frame_t           frame_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drive_en && !in_tail));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && drive_en && bit_idx == '0));

  p_stop_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && bit_idx == LAST_IDX) |-> drive_en);

  p_step_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && $past(sending) && bit_idx != $past(bit_idx))
      |-> (bit_idx == $past(bit_idx) + 1'b1));

  p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> ($stable(bit_idx) && $stable(in_tail) && busy));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sending |-> !drive_en);

  p_drop_from_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(in_tail));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(frame_q));
endmodule

bind resp_frame_tx resp_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .tick_en  (tick_en),
  .busy     (busy),
  .drive_en (drive_en),
  .sending  (sending),
  .in_tail  (in_tail),
  .bit_idx  (bit_idx),
  .frame_q  (frame_q)
);

// File: tb/tb_resp_frame_tx.sv
module tb_resp_frame_tx;
  localparam int BT = 3;
  localparam int FRAME_TICKS = 17 * BT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] car_id = '0;
  logic [1:0] trk_status = '0;
  logic [2:0] sender_id = '0;
  logic [3:0] dev_type = '0;
  logic       drive_en, drive_val, busy;
  int         tick_mode = 0;
  int         checks = 0;
  int         failures = 0;

  resp_frame_tx #(.BIT_TICKS(BT)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
    .car_id(car_id), .trk_status(trk_status), .sender_id(sender_id),
    .dev_type(dev_type), .drive_en(drive_en), .drive_val(drive_val), .busy(busy)
  );

  always #10 clk = ~clk;

  // tick pattern: 0 = every cycle, 1 = random, 2 = stalled
  always @(posedge clk) begin
    #2;
    case (tick_mode)
      0:       tick_en <= 1'b1;
      1:       tick_en <= ($urandom % 3) != 0;
      default: tick_en <= 1'b0;
    endcase
  end

  function automatic logic [15:0] exp_word(input logic [2:0] c, input logic [1:0] s,
                                           input logic [2:0] i, input logic [3:0] d);
    logic [15:0] w;
    w = 16'h8001;
    w = w | (16'(c) << 1) | (16'(s) << 4) | (16'(i) << 6) | (16'(d) << 9);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge with the block idle (or with a held start already pending).
  task automatic run_frame(input logic [2:0] c, input logic [1:0] s, input logic [2:0] i,
                           input logic [3:0] d, input bit poke, input bit freeze,
                           input bit hold, input logic [2:0] nc, input logic [1:0] ns,
                           input logic [2:0] ni, input logic [3:0] nd);
    logic [15:0] ef;
    int n, cyc, saved_mode;
    int e_frm, e_dat, e_gap, e_busy;
    int a_dat, x_dat, a_frm;
    bit t, xd;
    ef = exp_word(c, s, i, d);
    n = 0; cyc = 0; e_frm = 0; e_dat = 0; e_gap = 0; e_busy = 0;
    a_dat = 0; x_dat = 0; a_frm = 0;
    saved_mode = tick_mode;
    start = 1'b1; car_id = c; trk_status = s; sender_id = i; dev_type = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    car_id = ~c; trk_status = ~s; sender_id = ~i; dev_type = ~d;
    while (n < FRAME_TICKS && cyc < 2000) begin
      xd = (n / BT < 16) ? ef[n / BT] : 1'b0;
      if (drive_en !== xd) begin
        if (n / BT == 0 || n / BT == 15) begin e_frm++; a_frm = n / BT; end
        else if (n / BT < 16) begin
          if (e_dat == 0) begin a_dat = int'(drive_en); x_dat = int'(xd); end
          e_dat++;
        end else e_gap++;
      end
      if (busy !== 1'b1) e_busy++;
      if (poke && n < 16 * BT) begin
        start = 1'($urandom); car_id = 3'($urandom); trk_status = 2'($urandom);
        sender_id = 3'($urandom); dev_type = 4'($urandom);
      end
      if (hold && n >= 16 * BT) begin
        start = 1'b1; car_id = nc; trk_status = ns; sender_id = ni; dev_type = nd;
      end
      if (freeze && cyc == 10) tick_mode = 2;
      if (freeze && cyc == 30) tick_mode = saved_mode;
      t = tick_en;
      @(posedge clk);
      if (t) n++;
      @(negedge clk);
      cyc++;
    end
    start = hold;
    chk(e_frm == 0, "R4 framing bit (index shown)", a_frm, 1);
    chk(e_dat == 0, "R3 R5 R6 R7 payload bit value", a_dat, x_dat);
    chk(e_gap == 0 && drive_en === 1'b0, "R8 line released after stop bit", int'(drive_en), 0);
    chk(e_busy == 0 && busy === 1'b0, "R9 busy length", int'(busy), 0);
    if (poke) chk(e_dat == 0 && e_frm == 0, "R10 start during frame ignored", e_dat + e_frm, 0);
    if (freeze) chk(e_dat == 0, "R6 stalled ticks hold the bit", e_dat, 0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    start = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(drive_en === 1'b0, "R1 driver off after reset", int'(drive_en), 0);
    chk(drive_val === 1'b1, "R1 drive level", int'(drive_val), 1);

    // accept timing
    start = 1'b1; car_id = 3'd0; trk_status = 2'd0; sender_id = 3'd0; dev_type = 4'd0;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && drive_en === 1'b1, "R2 busy and start bit after accept",
        {busy, drive_en}, 3);
    while (busy) @(negedge clk);

    // directed corners, every status code
    run_frame(3'd0, TRK_CODE(0), 3'd0, 4'd0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(3'd7, TRK_CODE(3), 3'd7, 4'hF, 0, 0, 0, 0, 0, 0, 0);
    run_frame(3'd5, TRK_CODE(1), 3'd2, 4'hA, 0, 0, 0, 0, 0, 0, 0);
    run_frame(3'd2, TRK_CODE(2), 3'd5, 4'h5, 0, 1, 0, 0, 0, 0, 0);
    run_frame(3'd3, TRK_CODE(3), 3'd1, 4'h9, 1, 0, 0, 0, 0, 0, 0);

    // R11 held start chains two frames back to back
    run_frame(3'd1, 2'd1, 3'd6, 4'h3, 0, 0, 1, 3'd6, 2'd2, 3'd4, 4'hC);
    @(negedge clk);
    chk(busy === 1'b1 && drive_en === 1'b1, "R11 held start accepted when idle",
        {busy, drive_en}, 3);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(drive_en === 1'b0 && busy === 1'b0, "R8 line stays released while idle",
        {busy, drive_en}, 0);

    // random
    for (int k = 0; k < 24; k++) begin
      tick_mode = int'($urandom % 2);
      run_frame(3'($urandom), 2'($urandom), 3'($urandom), 4'($urandom),
                1'($urandom), (k % 6) == 0, 0, 0, 0, 0, 0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [1:0] TRK_CODE(input int v);
    return 2'(v);
  endfunction
endmodule